// File: doc/BRIEF.md
# Composite Clock Root Generator

This block derives one root clock from a handful of parent clocks. All parents live in the system clock domain and each one arrives as a single-cycle enable pulse. A 32-bit control word chooses the parent and sets two cascaded integer dividers, a coarse one and a fine one. It also carries an enable bit that gates the result. The root clock leaves the block as a single-cycle pulse on `root_pulse`.

Software changes the word by read-modify-write. The whole word is readable at any time on `rd_data`. A write that replaces it takes effect at the next clock edge. A write that changes the select or divider fields also restarts both divider counters, so the new ratio applies from the first pulse after the change.

A select value that names no existing parent raises `sel_err`, and the block then emits nothing. A small controller tracks the mode with three states:
- ST_OFF: the enable bit is clear.
- ST_RUN: enabled with a valid parent.
- ST_FAULT: enabled with an invalid parent.

It moves between them on these transitions:
- T_ENABLE: ST_OFF to ST_RUN or ST_FAULT.
- T_DISABLE: ST_RUN or ST_FAULT to ST_OFF.
- T_BADSEL: ST_RUN to ST_FAULT.
- T_GOODSEL: ST_FAULT to ST_RUN.

Each transition is taken at the same edge at which the new word is stored.

Top module: `clk_root_gen`

## Requirements
- R1: A synchronous active-high `rst` clears the control word to zero. That means disabled, parent 0 and both divisors 1. After reset `rd_data` is 0 and both `root_pulse` and `sel_err` are 0.
- R2: A write with `wr_en` high stores `wr_data` at the next edge. Only the defined bits are kept: bit 28, bits 26:24, bits 18:16 and bits 5:0. The other bits read as zero, so writing 0xFFFFFFFF reads back 0x1707003F. Without a write the word holds.
- R3: Bit 28 is the root enable. While it is 0, `root_pulse` stays low whatever the parents do.
- R4: Bits 26:24 hold the parent index. Only pulses on `parent_pulse[index]` advance the dividers; pulses on the other parents have no effect on the output.
- R5: Bits 18:16 set the pre-divider, which divides by the field value plus one (1 to 8).
- R6: Bits 5:0 set the post-divider, which divides by the field value plus one (1 to 64). It counts pre-divider outputs, so N selected parent pulses give floor(N / ((pre+1)·(post+1))) root pulses when counting starts fresh.
- R7: An index equal to or above `NUM_PARENTS` makes `sel_err` high (combinationally from the stored word). While that is so, `root_pulse` stays low.
- R8: A write that changes any select or divider bit clears both divider counters. A root pulse appears on the cycle after the parent pulse that completes the count.
- R9: `root_pulse` lasts one cycle per completed count and is only produced in the cycle after a parent pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | New control word |
| rd_data | output | 32 | Current control word, undefined bits zero |
| parent_pulse | input | NUM_PARENTS | One enable pulse per parent clock tick |
| root_pulse | output | 1 | Divided, gated root clock pulse |
| sel_err | output | 1 | Stored parent index names no parent |

## Verification
Some properties are checked on every cycle:
- The root output stays silent the cycle after the word shows a cleared enable or an invalid index.
- Every root pulse follows a parent pulse.
- A write lands in the word with its undefined bits dropped, and the word holds when there is no write.
- Each divider count stays within its programmed limit and returns to zero after a clear.

The exact division ratios, the choice of parent and the restart of the counters after a reconfiguration can only be shown by the bench's scenarios. The bench feeds known numbers of parent pulses and counts the root pulses. A cycle-level reference model also runs alongside the design throughout.

// File: rtl/clk_root_pkg.sv
package clk_root_pkg;

    localparam int CTRL_W   = 32;
    localparam int EN_BIT   = 28;
    localparam int SEL_LSB  = 24;
    localparam int SEL_W    = 3;
    localparam int PRE_LSB  = 16;
    localparam int PRE_W    = 3;
    localparam int POST_LSB = 0;
    localparam int POST_W   = 6;
    localparam int CMP_W    = SEL_W + 1;

    localparam logic [CTRL_W-1:0] EN_MASK   = CTRL_W'(1) << EN_BIT;
    localparam logic [CTRL_W-1:0] SEL_MASK  = ((CTRL_W'(1) << SEL_W) - 1) << SEL_LSB;
    localparam logic [CTRL_W-1:0] PRE_MASK  = ((CTRL_W'(1) << PRE_W) - 1) << PRE_LSB;
    localparam logic [CTRL_W-1:0] POST_MASK = ((CTRL_W'(1) << POST_W) - 1) << POST_LSB;
    localparam logic [CTRL_W-1:0] CFG_MASK  = SEL_MASK | PRE_MASK | POST_MASK;
    localparam logic [CTRL_W-1:0] DEF_MASK  = CFG_MASK | EN_MASK;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_RUN   = 2'd1,
        ST_FAULT = 2'd2
    } root_state_t;

    function automatic logic sel_in_range(input logic [SEL_W-1:0] sel, input int n);
        return ({1'b0, sel} < CMP_W'(n));
    endfunction

endpackage

// File: rtl/clk_root_ctrl_reg.sv
module clk_root_ctrl_reg
    import clk_root_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              en_q,
    output logic [SEL_W-1:0]  sel_q,
    output logic [PRE_W-1:0]  pre_q,
    output logic [POST_W-1:0] post_q,
    output logic              en_d,
    output logic [SEL_W-1:0]  sel_d,
    output logic              cfg_chg
);

    logic [CTRL_W-1:0] ctrl_d;

    always_comb begin
        ctrl_d  = wr_en ? (wr_data & DEF_MASK) : ctrl_q;
        cfg_chg = wr_en && (((ctrl_d ^ ctrl_q) & CFG_MASK) != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    assign en_q   = ctrl_q[EN_BIT];
    assign sel_q  = ctrl_q[SEL_LSB +: SEL_W];
    assign pre_q  = ctrl_q[PRE_LSB +: PRE_W];
    assign post_q = ctrl_q[POST_LSB +: POST_W];
    assign en_d   = ctrl_d[EN_BIT];
    assign sel_d  = ctrl_d[SEL_LSB +: SEL_W];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctrl_q == ($past(wr_data) & DEF_MASK))); // R2
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q)); // R2

endmodule

// File: rtl/clk_root_parent_mux.sv
module clk_root_parent_mux
    import clk_root_pkg::*;
#(
    parameter int NUM_PARENTS = 5
) (
    input  logic [NUM_PARENTS-1:0] parent_pulse,
    input  logic [SEL_W-1:0]       sel,
    output logic                   tick,
    output logic                   sel_ok
);

    logic [NUM_PARENTS-1:0] hit;

    for (genvar g = 0; g < NUM_PARENTS; g++) begin : g_hit
        assign hit[g] = parent_pulse[g] && (sel == SEL_W'(g));
    end

    assign sel_ok = sel_in_range(sel, NUM_PARENTS);
    assign tick   = sel_ok && (|hit);

endmodule

// File: rtl/clk_root_div_stage.sv
module clk_root_div_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [W-1:0] div,
    input  logic         tick_in,
    output logic         tick_out
);

    logic [W-1:0] cnt;
    logic         wrap;

    assign wrap     = (cnt == div);
    assign tick_out = tick_in && !clr && wrap;

    always_ff @(posedge clk) begin
        if (rst || clr)   cnt <= '0;
        else if (tick_in) cnt <= wrap ? '0 : cnt + 1'b1;
    end

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= div); // R5 R6
    AST_CLEAR_RESTARTS: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0)); // R8

endmodule

// File: rtl/clk_root_gen.sv
module clk_root_gen
    import clk_root_pkg::*;
#(
    parameter int NUM_PARENTS = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_en,
    input  logic [31:0]            wr_data,
    output logic [31:0]            rd_data,
    input  logic [NUM_PARENTS-1:0] parent_pulse,
    output logic                   root_pulse,
    output logic                   sel_err
);

    logic              en_q, en_d, cfg_chg;
    logic [SEL_W-1:0]  sel_q, sel_d;
    logic [PRE_W-1:0]  pre_q;
    logic [POST_W-1:0] post_q;
    logic              src_tick, sel_ok, pre_tick, post_tick, clr_div, valid_d;
    logic              root_q;
    root_state_t       state_q, state_d;

    clk_root_ctrl_reg i_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl_q  (rd_data),
        .en_q    (en_q),
        .sel_q   (sel_q),
        .pre_q   (pre_q),
        .post_q  (post_q),
        .en_d    (en_d),
        .sel_d   (sel_d),
        .cfg_chg (cfg_chg)
    );

    clk_root_parent_mux #(.NUM_PARENTS(NUM_PARENTS)) i_mux (
        .parent_pulse (parent_pulse),
        .sel          (sel_q),
        .tick         (src_tick),
        .sel_ok       (sel_ok)
    );

    assign clr_div = (state_q != ST_RUN) || cfg_chg;

    clk_root_div_stage #(.W(PRE_W)) i_pre (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_div),
        .div      (pre_q),
        .tick_in  (src_tick),
        .tick_out (pre_tick)
    );

    clk_root_div_stage #(.W(POST_W)) i_post (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr_div),
        .div      (post_q),
        .tick_in  (pre_tick),
        .tick_out (post_tick)
    );

    assign valid_d = sel_in_range(sel_d, NUM_PARENTS);

    // next-state decode from the word being stored this edge
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF:   if (en_d) state_d = valid_d ? ST_RUN : ST_FAULT;     // T_ENABLE
            ST_RUN:   if (!en_d) state_d = ST_OFF;                         // T_DISABLE
                      else if (!valid_d) state_d = ST_FAULT;               // T_BADSEL
            ST_FAULT: if (!en_d) state_d = ST_OFF;                         // T_DISABLE
                      else if (valid_d) state_d = ST_RUN;                  // T_GOODSEL
            default:  state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_OFF;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) root_q <= 1'b0;
        else     root_q <= (state_q == ST_RUN) && post_tick;
    end

    assign root_pulse = root_q;
    assign sel_err    = !sel_ok;

    AST_OFF_SILENT: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !root_pulse); // R3
    AST_BAD_SEL_SILENT: assert property (@(posedge clk) disable iff (rst)
        sel_err |=> !root_pulse); // R7
    AST_PULSE_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        root_pulse |-> $past(|parent_pulse)); // R9

endmodule

// File: tb/test_clk_root_gen.sv
`timescale 1ns/1ps
module test_clk_root_gen;

    localparam int NP = 5;
    localparam logic [31:0] MASK = 32'h1707_003F;
    localparam logic [31:0] CFGM = 32'h0707_003F;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [31:0]   wr_data = '0;
    logic [31:0]   rd_data;
    logic [NP-1:0] parent_pulse = '0;
    logic          root_pulse;
    logic          sel_err;

    int checks = 0;
    int errors = 0;
    int seen = 0;
    bit model_live = 1'b0;

    logic [31:0] m_ctrl;
    int          m_pre, m_post;
    logic        m_exp;

    always #2 clk = ~clk;

    clk_root_gen #(.NUM_PARENTS(NP)) i_clk_root_gen (
        .clk          (clk),
        .rst          (rst),
        .wr_en        (wr_en),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .parent_pulse (parent_pulse),
        .root_pulse   (root_pulse),
        .sel_err      (sel_err)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    // behavioural reference, updated on each rising edge
    always @(posedge clk) begin
        logic [31:0] nc;
        int sel, pd, qd;
        bit run, chg, pt, qt;
        if (rst) begin
            m_ctrl = '0; m_pre = 0; m_post = 0; m_exp = 1'b0; model_live = 1'b1;
        end else begin
            sel = int'(m_ctrl[26:24]);
            pd  = int'(m_ctrl[18:16]);
            qd  = int'(m_ctrl[5:0]);
            run = m_ctrl[28] && (sel < NP);
            nc  = wr_en ? (wr_data & MASK) : m_ctrl;
            chg = wr_en && (((nc ^ m_ctrl) & CFGM) != 0);
            if (!run || chg) begin
                m_pre = 0; m_post = 0; m_exp = 1'b0;
            end else begin
                pt = 0; qt = 0;
                if (parent_pulse[sel]) begin
                    if (m_pre == pd) begin m_pre = 0; pt = 1; end
                    else m_pre++;
                end
                if (pt) begin
                    if (m_post == qd) begin m_post = 0; qt = 1; end
                    else m_post++;
                end
                m_exp = qt;
            end
            m_ctrl = nc;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (!rst && model_live) begin
            check("R9 model root_pulse", {31'b0, root_pulse}, {31'b0, m_exp});
            check("R2 model rd_data", rd_data, m_ctrl);
            check("R7 model sel_err", {31'b0, sel_err}, {31'b0, (int'(m_ctrl[26:24]) >= NP)});
            if (root_pulse) seen++;
        end
    end

    function automatic logic [31:0] cfg(input bit en, input int sel, input int pre, input int post);
        return ({31'b0, en} << 28) | (32'(sel) << 24) | (32'(pre) << 16) | 32'(post);
    endfunction

    task automatic write_word(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic pulses(input logic [NP-1:0] mask, input int n, input int gap);
        #1 seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); parent_pulse = mask;
            for (int j = 0; j < gap; j++) begin
                @(negedge clk); parent_pulse = '0;
            end
        end
        @(negedge clk); parent_pulse = '0;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        #1;
        check("R1 reset rd_data", rd_data, 32'h0);
        check("R1 reset root_pulse", {31'b0, root_pulse}, 32'h0);
        check("R1 reset sel_err", {31'b0, sel_err}, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R2: undefined bits dropped; index 7 is invalid -> R7
        write_word(32'hFFFF_FFFF);
        #1 check("R2 readback mask", rd_data, 32'h1707_003F);
        check("R7 sel_err for index 7", {31'b0, sel_err}, 32'h1);
        pulses('1, 40, 0);
        check("R7 no output with bad index", 32'(seen), 32'd0);

        // R3: disabled
        write_word(cfg(0, 0, 0, 0));
        pulses('1, 30, 0);
        check("R3 disabled no output", 32'(seen), 32'd0);

        // R4: only the selected parent counts
        write_word(cfg(1, 2, 0, 0));
        pulses(5'b00010, 20, 1);
        check("R4 other parent ignored", 32'(seen), 32'd0);
        pulses(5'b00100, 12, 1);
        check("R4 selected parent passes", 32'(seen), 32'd12);

        // R5: divide by 8
        write_word(cfg(1, 0, 7, 0));
        pulses(5'b00001, 64, 0);
        check("R5 pre divide by 8", 32'(seen), 32'd8);

        // R6: divide by 2*64 and by 4*3
        write_word(cfg(1, 4, 1, 63));
        pulses(5'b10000, 256, 0);
        check("R6 divide by 128", 32'(seen), 32'd2);
        write_word(cfg(1, 3, 3, 2));
        pulses(5'b01000, 120, 2);
        check("R6 divide by 12", 32'(seen), 32'd10);

        // R8: restart on reconfiguration
        write_word(cfg(1, 0, 3, 0));
        pulses(5'b00001, 2, 0);
        check("R8 partial count", 32'(seen), 32'd0);
        write_word(cfg(1, 0, 1, 0));
        pulses(5'b00001, 4, 0);
        check("R8 restart new ratio", 32'(seen), 32'd2);

        // R8: one-cycle latency
        write_word(cfg(1, 1, 0, 0));
        @(negedge clk); parent_pulse = 5'b00010;
        @(negedge clk); parent_pulse = '0;
        check("R8 pulse next cycle", {31'b0, root_pulse}, 32'h1);
        @(negedge clk);
        check("R9 single cycle pulse", {31'b0, root_pulse}, 32'h0);

        // R7 boundary: first invalid and last valid index
        write_word(cfg(1, NP, 0, 0));
        #1 check("R7 index NP invalid", {31'b0, sel_err}, 32'h1);
        pulses('1, 10, 0);
        check("R7 index NP silent", 32'(seen), 32'd0);
        write_word(cfg(1, NP - 1, 0, 0));
        #1 check("R7 index NP-1 valid", {31'b0, sel_err}, 32'h0);
        pulses('1, 10, 0);
        check("R4 last parent passes", 32'(seen), 32'd10);

        summary();
    end

endmodule